// File: doc/BRIEF.md
# Debug Exit and Restart Sequencer

This block takes a halted processor core back out of debug state. While the core sits in debug, the block keeps the debug clock selected, holds the scan chain in debug mode and raises the debug acknowledge. It also captures the branch target that the debugger clocks into the pipeline. The target is taken only when the breakpoint bit of the scan chain is low.

A restart happens in two steps. First the restart instruction is loaded into the test access port, which arms the block. Execution does not resume until the TAP state machine reaches Run-Test/Idle. Because of this, several cores driven from one TAP sequence can be armed ahead of time and then released on the same cycle.

On release the scan chain goes back to system mode and a two-flop synchroniser hands the core clock over to the memory clock, with one dead cycle in which neither clock is enabled. A programmable number of internal cycles follows. Then the pipeline is refilled with one nonsequential fetch at the target and two sequential fetches after it. The debug acknowledge stays high until the last refill fetch has completed, so the system can mask out every access the debugging caused.

Top module: `dbgx_exit`

## Requirements
- R1: After synchronous reset the core is running: dbg_ack=0, dclk_en=0, mclk_en=1, scan_sys_mode=1, mreq_n=1, seq=0, resume_req=0, fetch_addr=0.
- R2: While running, core_dbg=1 sampled at a clock edge puts the block in the halted state from that edge on: dbg_ack=1, dclk_en=1, mclk_en=0, scan_sys_mode=0. While halted, mreq_n stays 1.
- R3: While halted, branch_load=1 with bkpt_bit=0 stores branch_target as the refill base. With bkpt_bit=1 the load is ignored. This is observed through fetch_addr during the refill.
- R4: The block is armed when tap_state=4'hD (update-IR) is sampled with ir_code equal to the RESTART_IR parameter (default 4'h4). tap_state=4'hC (Run-Test/Idle) with ir_code=RESTART_IR but no prior arming has no effect: the block stays halted.
- R5: An armed block disarms when ir_code differs from RESTART_IR at a clock edge. A later Run-Test/Idle then has no effect until the block is armed again.
- R6: tap_state=4'hC sampled while armed starts the exit. From that edge scan_sys_mode=1, while dbg_ack=1 and dclk_en=1 remain.
- R7: After the exit starts, dclk_en stays 1 for three cycles, then neither clock enable is high for one cycle, then mclk_en=1. dclk_en and mclk_en are never both 1.
- R8: N_INT internal cycles (default 2) follow the dead cycle, with mreq_n=1 and seq=0.
- R9: Three refill fetches follow with mreq_n=0: fetch_addr=base with seq=0, then base+4 and base+8 with seq=1.
- R10: dbg_ack stays 1 through all three refill fetches and is 0 from the cycle after the base+8 fetch. The block is then running again.
- R11: resume_req is high for exactly one cycle, the cycle of the fetch at base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_state | input | 4 | Current TAP controller state code |
| ir_code | input | IRW | Currently selected TAP instruction |
| core_dbg | input | 1 | Core reports it has entered debug state |
| bkpt_bit | input | 1 | Breakpoint bit of the scan chain for the clocked instruction |
| branch_load | input | 1 | Strobe: a branch is being clocked into the pipeline |
| branch_target | input | AW | Target address of that branch |
| dbg_ack | output | 1 | Core in debug or debug-induced traffic in progress |
| dclk_en | output | 1 | Core clocked from the debug clock |
| mclk_en | output | 1 | Core clocked from the memory clock |
| scan_sys_mode | output | 1 | Scan chain in system mode |
| resume_req | output | 1 | Pulse marking the first refill fetch |
| mreq_n | output | 1 | Active-low memory request for refill fetches |
| seq | output | 1 | Refill fetch is sequential to the previous one |
| fetch_addr | output | AW | Refill fetch address, zero outside fetches |

## Verification
All outputs are decoded from registered state, so each output responds one clock edge after the input that causes it. The bench applies each stimulus on a falling edge and samples one time unit after the next rising edge. Release into the synchroniser takes three cycles of dclk_en, followed by one dead cycle and N_INT internal cycles. The fetch at base therefore falls 4+N_INT cycles after Run-Test/Idle is sampled, and dbg_ack drops 3 cycles after that. The vector table lists one expected output set per cycle, so every one of these latencies is checked on the exact cycle it is due.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;

    localparam int TAP_W       = 4;
    localparam logic [TAP_W-1:0] TAP_RUN_IDLE  = 4'hC;
    localparam logic [TAP_W-1:0] TAP_UPDATE_IR = 4'hD;

    localparam int REFILL_FETCHES = 3;
    localparam int WORD_BYTES     = 4;

    typedef enum logic [2:0] {
        XS_RUN,
        XS_HALT,
        XS_SYNC,
        XS_GAP,
        XS_REFILL
    } xstate_e;

    typedef struct packed {
        logic dclk_en;
        logic mclk_en;
    } clk_sel_t;

    function automatic clk_sel_t clk_sel_for(input xstate_e st);
        clk_sel_t c;
        c.dclk_en = (st == XS_HALT) || (st == XS_SYNC);
        c.mclk_en = (st == XS_RUN)  || (st == XS_REFILL);
        return c;
    endfunction

endpackage

// File: rtl/dbgx_restart_arm.sv
module dbgx_restart_arm
    import dbgx_pkg::*;
#(
    parameter int IRW = 4,
    parameter logic [IRW-1:0] RESTART_IR = 4'h4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halted,
    input  logic [TAP_W-1:0] tap_state,
    input  logic [IRW-1:0]   ir_code,
    output logic             fire
);

    logic armed;
    logic ir_is_restart;

    assign ir_is_restart = (ir_code == RESTART_IR);

    always_ff @(posedge clk) begin
        if (rst || !halted) begin
            armed <= 1'b0;
        end else if (tap_state == TAP_UPDATE_IR && ir_is_restart) begin
            armed <= 1'b1;
        end else if (!ir_is_restart) begin
            armed <= 1'b0;
        end
    end

    assign fire = halted && armed && (tap_state == TAP_RUN_IDLE);

endmodule

// File: rtl/dbgx_sync2.sv
module dbgx_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);

    logic req_q;
    logic s1_q;
    logic s2_q;

    always_ff @(posedge clk) begin
        if (rst || s2_q) begin
            req_q <= 1'b0;
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
        end else begin
            if (start) begin
                req_q <= 1'b1;
            end
            s1_q <= req_q;
            s2_q <= s1_q;
        end
    end

    assign done = s2_q;

endmodule

// File: rtl/dbgx_refill.sv
module dbgx_refill
    import dbgx_pkg::*;
#(
    parameter int AW    = 32,
    parameter int N_INT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base,
    output logic          last,
    output logic          mreq_n,
    output logic          seq,
    output logic          resume,
    output logic [AW-1:0] addr
);

    localparam int TOTAL = N_INT + REFILL_FETCHES;
    localparam int CW    = $clog2(TOTAL + 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic          fetching;
    logic [CW-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (last) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (N_INT == 0) begin : g_no_internal
            assign fetching = active;
            assign idx      = cnt;
        end else begin : g_internal
            assign fetching = active && (cnt >= CW'(N_INT));
            assign idx      = cnt - CW'(N_INT);
        end
    endgenerate

    assign last   = active && (cnt == CW'(TOTAL - 1));
    assign mreq_n = !fetching;
    assign seq    = fetching && (idx != '0);
    assign resume = fetching && (idx == '0);
    assign addr   = fetching ? (base + (AW'(idx) * AW'(WORD_BYTES))) : '0;

endmodule

// File: rtl/dbgx_exit.sv
module dbgx_exit
    import dbgx_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IRW   = 4,
    parameter int N_INT = 2,
    parameter logic [IRW-1:0] RESTART_IR = 4'h4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       tap_state,
    input  logic [IRW-1:0]   ir_code,
    input  logic             core_dbg,
    input  logic             bkpt_bit,
    input  logic             branch_load,
    input  logic [AW-1:0]    branch_target,
    output logic             dbg_ack,
    output logic             dclk_en,
    output logic             mclk_en,
    output logic             scan_sys_mode,
    output logic             resume_req,
    output logic             mreq_n,
    output logic             seq,
    output logic [AW-1:0]    fetch_addr
);

    xstate_e       state;
    logic          fire;
    logic          sync_done;
    logic          refill_last;
    logic [AW-1:0] target_q;
    clk_sel_t      csel;

    dbgx_restart_arm #(
        .IRW        (IRW),
        .RESTART_IR (RESTART_IR)
    ) u_arm (
        .clk       (clk),
        .rst       (rst),
        .halted    (state == XS_HALT),
        .tap_state (tap_state),
        .ir_code   (ir_code),
        .fire      (fire)
    );

    dbgx_sync2 u_sync (
        .clk   (clk),
        .rst   (rst),
        .start (fire),
        .done  (sync_done)
    );

    dbgx_refill #(
        .AW    (AW),
        .N_INT (N_INT)
    ) u_refill (
        .clk    (clk),
        .rst    (rst),
        .start  (state == XS_GAP),
        .base   (target_q),
        .last   (refill_last),
        .mreq_n (mreq_n),
        .seq    (seq),
        .resume (resume_req),
        .addr   (fetch_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= XS_RUN;
        end else begin
            unique case (state)
                XS_RUN:    if (core_dbg)    state <= XS_HALT;
                XS_HALT:   if (fire)        state <= XS_SYNC;
                XS_SYNC:   if (sync_done)   state <= XS_GAP;
                XS_GAP:                     state <= XS_REFILL;
                XS_REFILL: if (refill_last) state <= XS_RUN;
                default:                    state <= XS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
        end else if (state == XS_HALT && branch_load && !bkpt_bit) begin
            target_q <= branch_target;
        end
    end

    assign csel          = clk_sel_for(state);
    assign dclk_en       = csel.dclk_en;
    assign mclk_en       = csel.mclk_en;
    assign dbg_ack       = (state != XS_RUN);
    assign scan_sys_mode = (state != XS_HALT);

endmodule

// File: rtl/dbgx_exit_chk.sv
module dbgx_exit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          dbg_ack,
    input logic          dclk_en,
    input logic          mclk_en,
    input logic          scan_sys_mode,
    input logic          resume_req,
    input logic          mreq_n,
    input logic          seq,
    input logic [AW-1:0] fetch_addr
);

    AST_CLK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dclk_en && mclk_en)); // R7

    AST_DEAD_CYCLE: assert property (@(posedge clk) disable iff (rst)
        $fell(dclk_en) |-> !mclk_en); // R7

    AST_FIRST_NONSEQ: assert property (@(posedge clk) disable iff (rst)
        $fell(mreq_n) |-> (!seq && resume_req)); // R9

    AST_SEQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && seq) |-> !$past(mreq_n)); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && seq) |-> (fetch_addr == $past(fetch_addr) + AW'(4))); // R9

    AST_ACK_REFILL: assert property (@(posedge clk) disable iff (rst)
        !mreq_n |-> dbg_ack); // R10

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(dbg_ack) |-> $past(!mreq_n && seq)); // R10

    AST_RESUME_ONCE: assert property (@(posedge clk) disable iff (rst)
        resume_req |=> !resume_req); // R11

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (dbg_ack && !scan_sys_mode) |-> mreq_n); // R2

endmodule

bind dbgx_exit dbgx_exit_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dbg_ack       (dbg_ack),
    .dclk_en       (dclk_en),
    .mclk_en       (mclk_en),
    .scan_sys_mode (scan_sys_mode),
    .resume_req    (resume_req),
    .mreq_n        (mreq_n),
    .seq           (seq),
    .fetch_addr    (fetch_addr)
);

// File: tb/test_dbgx_exit.sv
module test_dbgx_exit;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 32;
    localparam int IRW = 4;
    localparam int NROWS = 19;

    localparam logic [3:0] T_RTI = 4'hC;
    localparam logic [3:0] T_UPD = 4'hD;
    localparam logic [3:0] T_OTH = 4'h2;
    localparam logic [3:0] I_RST = 4'h4;
    localparam logic [3:0] I_OTH = 4'hC;

    // expected bits: ack, dclk, mclk, scan, mreq_n, seq, resume
    localparam logic [6:0] E_HALT = 7'b1100100;
    localparam logic [6:0] E_SYNC = 7'b1101100;
    localparam logic [6:0] E_GAP  = 7'b1001100;
    localparam logic [6:0] E_INT  = 7'b1011100;
    localparam logic [6:0] E_F0   = 7'b1011001;
    localparam logic [6:0] E_FS   = 7'b1011010;
    localparam logic [6:0] E_RUN  = 7'b0011100;

    typedef struct packed {
        logic [3:0]  tap;
        logic [3:0]  ir;
        logic        halt;
        logic        load;
        logic        bp;
        logic [31:0] tgt;
        logic [6:0]  exp_bits;
        logic [31:0] exp_addr;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t mk(input logic [3:0] tp, input logic [3:0] ir,
                                input logic h, input logic ld, input logic bp,
                                input logic [31:0] tg, input logic [6:0] eb,
                                input logic [31:0] ea, input int r);
        vec_t v;
        v.tap = tp; v.ir = ir; v.halt = h; v.load = ld; v.bp = bp;
        v.tgt = tg; v.exp_bits = eb; v.exp_addr = ea; v.req = 8'(r);
        return v;
    endfunction

    localparam vec_t TBL [NROWS] = '{
        mk(T_OTH, I_OTH, 1, 0, 0, 32'h0,    E_HALT, 32'h0,    2),  // R2 halt entry
        mk(T_OTH, I_OTH, 1, 1, 1, 32'h2000, E_HALT, 32'h0,    3),  // R3 load with bp high ignored
        mk(T_OTH, I_OTH, 1, 1, 0, 32'h1000, E_HALT, 32'h0,    3),  // R3 load taken
        mk(T_RTI, I_RST, 1, 0, 0, 32'h0,    E_HALT, 32'h0,    4),  // R4 idle without arming
        mk(T_UPD, I_RST, 1, 0, 0, 32'h0,    E_HALT, 32'h0,    4),  // R4 arm
        mk(T_OTH, I_OTH, 1, 0, 0, 32'h0,    E_HALT, 32'h0,    5),  // R5 cancel
        mk(T_RTI, I_RST, 1, 0, 0, 32'h0,    E_HALT, 32'h0,    5),  // R5 idle after cancel
        mk(T_UPD, I_RST, 1, 0, 0, 32'h0,    E_HALT, 32'h0,    4),  // R4 re-arm
        mk(T_OTH, I_RST, 1, 0, 0, 32'h0,    E_HALT, 32'h0,    4),  // R4 still armed
        mk(T_RTI, I_RST, 0, 0, 0, 32'h0,    E_SYNC, 32'h0,    6),  // R6 release
        mk(T_OTH, I_RST, 0, 0, 0, 32'h0,    E_SYNC, 32'h0,    7),  // R7 debug clock held
        mk(T_OTH, I_RST, 0, 0, 0, 32'h0,    E_SYNC, 32'h0,    7),  // R7
        mk(T_OTH, I_RST, 0, 0, 0, 32'h0,    E_GAP,  32'h0,    7),  // R7 dead cycle
        mk(T_OTH, I_RST, 0, 0, 0, 32'h0,    E_INT,  32'h0,    8),  // R8 internal
        mk(T_OTH, I_RST, 0, 0, 0, 32'h0,    E_INT,  32'h0,    8),  // R8 internal
        mk(T_OTH, I_RST, 0, 0, 0, 32'h0,    E_F0,   32'h1000, 11), // R11 nonseq fetch + resume
        mk(T_OTH, I_RST, 0, 0, 0, 32'h0,    E_FS,   32'h1004, 9),  // R9 seq fetch
        mk(T_OTH, I_RST, 0, 0, 0, 32'h0,    E_FS,   32'h1008, 9),  // R9 seq fetch
        mk(T_OTH, I_RST, 0, 0, 0, 32'h0,    E_RUN,  32'h0,    10)  // R10 ack drops
    };

    logic            clk = 1'b0;
    logic            rst;
    logic [3:0]      tap_state;
    logic [IRW-1:0]  ir_code;
    logic            core_dbg;
    logic            bkpt_bit;
    logic            branch_load;
    logic [AW-1:0]   branch_target;
    logic            dbg_ack, dclk_en, mclk_en, scan_sys_mode;
    logic            resume_req, mreq_n, seq;
    logic [AW-1:0]   fetch_addr;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbgx_exit i_dbgx_exit (
        .clk           (clk),
        .rst           (rst),
        .tap_state     (tap_state),
        .ir_code       (ir_code),
        .core_dbg      (core_dbg),
        .bkpt_bit      (bkpt_bit),
        .branch_load   (branch_load),
        .branch_target (branch_target),
        .dbg_ack       (dbg_ack),
        .dclk_en       (dclk_en),
        .mclk_en       (mclk_en),
        .scan_sys_mode (scan_sys_mode),
        .resume_req    (resume_req),
        .mreq_n        (mreq_n),
        .seq           (seq),
        .fetch_addr    (fetch_addr)
    );

    function automatic logic [6:0] obs_bits();
        return {dbg_ack, dclk_en, mclk_en, scan_sys_mode, mreq_n, seq, resume_req};
    endfunction

    task automatic check(input string tag, input logic [6:0] eb, input logic [31:0] ea);
        n_checks++;
        if (obs_bits() !== eb || fetch_addr !== ea) begin
            n_fail++;
            $display("FAIL %s: bits=%b addr=%h expected bits=%b addr=%h",
                     tag, obs_bits(), fetch_addr, eb, ea);
        end
    endtask

    task automatic drive(input logic [3:0] tp, input logic [3:0] ir, input logic h,
                         input logic ld, input logic bp, input logic [31:0] tg);
        @(negedge clk);
        tap_state = tp; ir_code = ir; core_dbg = h;
        branch_load = ld; bkpt_bit = bp; branch_target = tg;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1;
        tap_state = T_OTH; ir_code = I_OTH; core_dbg = 1'b0;
        bkpt_bit = 1'b0; branch_load = 1'b0; branch_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset state", E_RUN, 32'h0);

        // R4: restart selection while running has no effect
        drive(T_UPD, I_RST, 0, 0, 0, 32'h0);
        drive(T_RTI, I_RST, 0, 0, 0, 32'h0);
        check("R4 restart while running", E_RUN, 32'h0);

        for (int i = 0; i < NROWS; i++) begin
            drive(TBL[i].tap, TBL[i].ir, TBL[i].halt, TBL[i].load, TBL[i].bp, TBL[i].tgt);
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].exp_bits, TBL[i].exp_addr);
        end

        // R2: a second debug entry after resuming
        drive(T_OTH, I_OTH, 1, 0, 0, 32'h0);
        check("R2 re-entry to debug", E_HALT, 32'h0);

        // R3: the stored base survives into a second exit when no new load is taken
        drive(T_UPD, I_RST, 0, 1, 1, 32'h3000);
        drive(T_RTI, I_RST, 0, 0, 0, 32'h0);
        check("R6 second release", E_SYNC, 32'h0);
        repeat (6) drive(T_OTH, I_OTH, 0, 0, 0, 32'h0);
        check("R3 base kept, R9 fetch at base", E_F0, 32'h1000);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule